// File: doc/BRIEF.md
# DRAM Frequency-Switch Sequencer with Staged Refresh Timing

This block steps a DRAM subsystem through a clock-frequency change once software sets a start bit in its control register. The sequence waits until every bus master is idle or masked. It then puts the DRAM into self-refresh, optionally holds the I/O pads, and asks a clock generator to switch. After that it loads the new refresh timing, releases the pads, leaves self-refresh and reports completion by clearing the start bit.

Software can stage the refresh timing for the new frequency ahead of time. While the buffer-timing enable is set, writes to the timing register go to a shadow copy. The timing that drives the memory controller changes only at the commit point inside the sequence. Each handshake wait has a programmable cycle limit. When a wait runs out, the sequence aborts safely and sets a sticky error flag.

Top module: `dfs_seq_top`

## Requirements
- R1: After reset, CTRL (address 0) reads 0, MASK (address 1) reads 0, TIMING (address 2) and SHADOW (address 3) read TIMING_RST, and sr_req, pad_hold and clk_req are low.
- R2: Writing CTRL with bit 0 set while idle starts a sequence. Bit 0 then reads 1 until the sequence ends and reads 0 afterwards. While a sequence runs, every CTRL write is ignored, including a second start, and the CTRL fields keep their values.
- R3: The sequence does not raise sr_req until, for every master i, mst_ready[i] is 1 or MASK bit i is 1. A MASK of all ones lets the sequence proceed with no master ready.
- R4: The handshakes run in this order. sr_req rises first. After sr_ack arrives, pad_hold rises if CTRL bit 13 is set. Then clk_req is raised and held until clk_ack. clk_req and pad_hold are only ever high while sr_req is high. sr_req falls only after clk_req has fallen and clk_ack has returned low. The sequence ends once sr_ack is low.
- R5: With CTRL bit 15 (buffer-timing) set, a TIMING write changes only SHADOW (readable at address 3). The active timing (read at address 2 and driven on ref_interval and ref_cycles) takes the shadow value only after clk_ack has been seen in a sequence.
- R6: With CTRL bit 15 clear, a TIMING write updates the active timing and the shadow copy in the next cycle.
- R7: When a handshake wait lasts longer than TIMEOUT (address 4) cycles, the sequence aborts. It drops sr_req, pad_hold and clk_req, clears CTRL bit 0 and sets the sticky error flag at CTRL bit 8. The active timing does not take the shadow value if clk_ack never came. The flag clears only when the next sequence is accepted.
- R8: ref_interval carries active timing bits 31:16 (refresh interval in units of 32 controller clocks), and ref_cycles carries bits 15:0 (refresh cycle time in controller clocks).
- R9: CTRL bit 1 drives cfg_alt_mode (0 selects dynamic frequency scaling, 1 selects the alternate mode), and CTRL bit 4 drives cfg_bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mst_ready | input | NUM_MST | Per-master ready flags |
| sr_req | output | 1 | Self-refresh request (level) |
| sr_ack | input | 1 | Self-refresh acknowledge (level) |
| pad_hold | output | 1 | Pad hold control |
| clk_req | output | 1 | Clock change request (level) |
| clk_ack | input | 1 | Clock change acknowledge (level) |
| cfg_alt_mode | output | 1 | Mode select to the clock generator |
| cfg_bypass | output | 1 | Bypass select to the clock generator |
| ref_interval | output | 16 | Active refresh interval field |
| ref_cycles | output | 16 | Active refresh cycle-time field |

## Verification
The bench builds the block with NUM_MST = 4 so that masking and partial readiness can be covered with a few patterns. It uses TMO_RST = 1000 so that normal handshakes never come near the limit. The bench then programs TIMEOUT down to 20 cycles, which brings the abort path within reach in a short run. It also sets TIMING_RST to a distinctive value so that a staged timing value can be told apart from the reset value.

// File: rtl/dfs_pkg.sv
// Package: shared state encoding and register addresses for the
// frequency-switch sequencer. Assumes a 3-bit word address space.
package dfs_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WAIT_MST,
        ST_SR_ON,
        ST_PAD_ON,
        ST_CLK_ON,
        ST_COMMIT,
        ST_CLK_OFF,
        ST_PAD_OFF,
        ST_SR_OFF
    } seq_state_t;

    localparam logic [2:0] A_CTRL    = 3'd0;
    localparam logic [2:0] A_MASK    = 3'd1;
    localparam logic [2:0] A_TIMING  = 3'd2;
    localparam logic [2:0] A_SHADOW  = 3'd3;
    localparam logic [2:0] A_TIMEOUT = 3'd4;

    localparam int B_START = 0;
    localparam int B_MODE  = 1;
    localparam int B_BYP   = 4;
    localparam int B_ERR   = 8;
    localparam int B_PAD   = 13;
    localparam int B_BUF   = 15;
endpackage

// File: rtl/dfs_ready_gate.sv
// Module: combines the per-master ready flags with the mask.
// Assumes: NUM_MST <= 32. A master counts as clear when it is ready or masked.
module dfs_ready_gate #(
    parameter int NUM_MST = 8
) (
    input  logic [NUM_MST-1:0] ready,
    input  logic [NUM_MST-1:0] mask,
    output logic               all_ok
);
    logic [NUM_MST-1:0] ok;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_MST; gi++) begin : g_mst
            // per-master clear flag
            assign ok[gi] = ready[gi] | mask[gi];
        end
    endgenerate

    // reduce to one flag
    assign all_ok = &ok;
endmodule

// File: rtl/dfs_wait_timer.sv
// Module: counts the cycles of one handshake wait.
// Assumes: waiting drops for at least one cycle between waits, which clears
// the count. expired is raised on the wait cycle whose count equals limit.
module dfs_wait_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             waiting,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);
    logic [TMO_W-1:0] cnt;

    // count the cycles spent in the current wait, cleared outside it
    always_ff @(posedge clk) begin
        if (!rst_n || !waiting) begin
            cnt <= '0;
        end else if (cnt != limit) begin
            cnt <= cnt + 1'b1;
        end
    end

    // wait limit reached
    assign expired = waiting && (cnt == limit);
endmodule

// File: rtl/dfs_seq_fsm.sv
// Module: sequencer state machine for the clock switch.
// Assumes: level handshakes on self-refresh and the clock change. Every wait
// is bounded by the timer, and on expiry the machine returns straight to idle.
module dfs_seq_fsm
    import dfs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic pad_en,
    input  logic all_ok,
    input  logic sr_ack,
    input  logic clk_ack,
    input  logic tmo_expired,
    output logic busy,
    output logic waiting,
    output logic sr_req,
    output logic pad_hold,
    output logic clk_req,
    output logic commit,
    output logic abort
);
    seq_state_t state, nxt;

    // wait condition of the current state is not yet met
    always_comb begin
        unique case (state)
            ST_WAIT_MST: waiting = !all_ok;
            ST_SR_ON:    waiting = !sr_ack;
            ST_CLK_ON:   waiting = !clk_ack;
            ST_CLK_OFF:  waiting = clk_ack;
            ST_SR_OFF:   waiting = sr_ack;
            default:     waiting = 1'b0;
        endcase
    end

    assign abort = waiting && tmo_expired;

    // next-state selection
    always_comb begin
        nxt = state;
        if (abort) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     if (go) nxt = ST_WAIT_MST;
                ST_WAIT_MST: if (all_ok) nxt = ST_SR_ON;
                ST_SR_ON:    if (sr_ack) nxt = ST_PAD_ON;
                ST_PAD_ON:   nxt = ST_CLK_ON;
                ST_CLK_ON:   if (clk_ack) nxt = ST_COMMIT;
                ST_COMMIT:   nxt = ST_CLK_OFF;
                ST_CLK_OFF:  if (!clk_ack) nxt = ST_PAD_OFF;
                ST_PAD_OFF:  nxt = ST_SR_OFF;
                ST_SR_OFF:   if (!sr_ack) nxt = ST_IDLE;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // output decode from the state
    always_comb begin
        busy     = (state != ST_IDLE);
        sr_req   = (state == ST_SR_ON) || (state == ST_PAD_ON) || (state == ST_CLK_ON) ||
                   (state == ST_COMMIT) || (state == ST_CLK_OFF) || (state == ST_PAD_OFF);
        pad_hold = pad_en && ((state == ST_PAD_ON) || (state == ST_CLK_ON) ||
                              (state == ST_COMMIT) || (state == ST_CLK_OFF));
        clk_req  = (state == ST_CLK_ON);
        commit   = (state == ST_COMMIT);
    end

    AST_CLK_IN_SR: assert property (@(posedge clk) disable iff (!rst_n)
        clk_req |-> sr_req); // R4
    AST_PAD_IN_SR: assert property (@(posedge clk) disable iff (!rst_n)
        pad_hold |-> sr_req); // R4
    AST_MST_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_MST && !all_ok) |=> !sr_req); // R3
    AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!sr_req && !clk_req && !pad_hold && !busy)); // R7
endmodule

// File: rtl/dfs_regs.sv
// Module: register file with the shadowed refresh timing.
// Assumes: single-cycle writes and combinational reads. CTRL is frozen
// while the sequence runs, and the error flag clears when a start is accepted.
module dfs_regs
    import dfs_pkg::*;
#(
    parameter int          NUM_MST    = 8,
    parameter int          ADDR_W     = 3,
    parameter int          TMO_W      = 16,
    parameter logic [31:0] TIMING_RST = 32'h0000_0000,
    parameter logic [TMO_W-1:0] TMO_RST = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               busy,
    input  logic               commit,
    input  logic               abort,
    output logic               go,
    output logic               pad_en,
    output logic               buf_en,
    output logic               alt_mode,
    output logic               bypass,
    output logic [NUM_MST-1:0] mask,
    output logic [TMO_W-1:0]   tmo_limit,
    output logic [31:0]        active_tim
);
    localparam int PAD_MSK = 32 - NUM_MST;

    logic        err_q;
    logic [31:0] shadow_tim;
    logic        wr_ctrl, wr_mask, wr_tim, wr_tmo;

    // write decode
    always_comb begin
        wr_ctrl = reg_wr && (reg_addr == ADDR_W'(A_CTRL));
        wr_mask = reg_wr && (reg_addr == ADDR_W'(A_MASK));
        wr_tim  = reg_wr && (reg_addr == ADDR_W'(A_TIMING));
        wr_tmo  = reg_wr && (reg_addr == ADDR_W'(A_TIMEOUT));
        go      = wr_ctrl && reg_wdata[B_START] && !busy;
    end

    // control fields, written only while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pad_en   <= 1'b0;
            buf_en   <= 1'b0;
            alt_mode <= 1'b0;
            bypass   <= 1'b0;
        end else if (wr_ctrl && !busy) begin
            pad_en   <= reg_wdata[B_PAD];
            buf_en   <= reg_wdata[B_BUF];
            alt_mode <= reg_wdata[B_MODE];
            bypass   <= reg_wdata[B_BYP];
        end
    end

    // sticky error flag: set on abort, cleared by an accepted start
    always_ff @(posedge clk) begin
        if (!rst_n)     err_q <= 1'b0;
        else if (abort) err_q <= 1'b1;
        else if (go)    err_q <= 1'b0;
    end

    // mask and timeout limit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask      <= '0;
            tmo_limit <= TMO_RST;
        end else begin
            if (wr_mask) mask      <= reg_wdata[NUM_MST-1:0];
            if (wr_tmo)  tmo_limit <= reg_wdata[TMO_W-1:0];
        end
    end

    // shadow timing copy: takes every timing write
    always_ff @(posedge clk) begin
        if (!rst_n)      shadow_tim <= TIMING_RST;
        else if (wr_tim) shadow_tim <= reg_wdata;
    end

    // active timing: direct write when unbuffered, commit when buffered
    always_ff @(posedge clk) begin
        if (!rst_n)                  active_tim <= TIMING_RST;
        else if (wr_tim && !buf_en)  active_tim <= reg_wdata;
        else if (commit && buf_en)   active_tim <= shadow_tim;
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_W'(A_CTRL): begin
                reg_rdata[B_START] = busy;
                reg_rdata[B_MODE]  = alt_mode;
                reg_rdata[B_BYP]   = bypass;
                reg_rdata[B_ERR]   = err_q;
                reg_rdata[B_PAD]   = pad_en;
                reg_rdata[B_BUF]   = buf_en;
            end
            ADDR_W'(A_MASK):    reg_rdata = {{PAD_MSK{1'b0}}, mask};
            ADDR_W'(A_TIMING):  reg_rdata = active_tim;
            ADDR_W'(A_SHADOW):  reg_rdata = shadow_tim;
            ADDR_W'(A_TIMEOUT): reg_rdata = 32'(tmo_limit);
            default:            reg_rdata = '0;
        endcase
    end

    AST_ACTIVE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active_tim) |-> ($past(commit && buf_en) || $past(wr_tim && !buf_en))); // R5 R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !go) |=> err_q); // R7
    AST_CTRL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(pad_en) && $stable(buf_en) && $stable(alt_mode) && $stable(bypass))); // R2
endmodule

// File: rtl/dfs_seq_top.sv
// Module: top of the DRAM frequency-switch sequencer.
// Assumes: one clock domain shared with the handshake partners, whose
// acknowledges are already synchronous to clk.
module dfs_seq_top #(
    parameter int          NUM_MST    = 8,
    parameter int          ADDR_W     = 3,
    parameter int          TMO_W      = 16,
    parameter logic [31:0] TIMING_RST = 32'h0000_0000,
    parameter logic [TMO_W-1:0] TMO_RST = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [NUM_MST-1:0] mst_ready,
    output logic               sr_req,
    input  logic               sr_ack,
    output logic               pad_hold,
    output logic               clk_req,
    input  logic               clk_ack,
    output logic               cfg_alt_mode,
    output logic               cfg_bypass,
    output logic [15:0]        ref_interval,
    output logic [15:0]        ref_cycles
);
    logic               go, pad_en, buf_en, busy, waiting, commit, abort;
    logic               all_ok, expired;
    logic [NUM_MST-1:0] mask;
    logic [TMO_W-1:0]   tmo_limit;
    logic [31:0]        active_tim;

    dfs_regs #(
        .NUM_MST(NUM_MST), .ADDR_W(ADDR_W), .TMO_W(TMO_W),
        .TIMING_RST(TIMING_RST), .TMO_RST(TMO_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
        .commit(commit), .abort(abort), .go(go), .pad_en(pad_en),
        .buf_en(buf_en), .alt_mode(cfg_alt_mode), .bypass(cfg_bypass),
        .mask(mask), .tmo_limit(tmo_limit), .active_tim(active_tim)
    );

    dfs_ready_gate #(.NUM_MST(NUM_MST)) u_gate (
        .ready(mst_ready), .mask(mask), .all_ok(all_ok)
    );

    dfs_wait_timer #(.TMO_W(TMO_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .waiting(waiting), .limit(tmo_limit),
        .expired(expired)
    );

    dfs_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .go(go), .pad_en(pad_en), .all_ok(all_ok),
        .sr_ack(sr_ack), .clk_ack(clk_ack), .tmo_expired(expired),
        .busy(busy), .waiting(waiting), .sr_req(sr_req), .pad_hold(pad_hold),
        .clk_req(clk_req), .commit(commit), .abort(abort)
    );

    // timing fields to the memory controller
    assign ref_interval = active_tim[31:16];
    assign ref_cycles   = active_tim[15:0];
endmodule

// File: tb/tb_dfs_seq_top.sv
module tb_dfs_seq_top;
    localparam int          NMST = 4;
    localparam logic [31:0] TRST = 32'h00F0_0040;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NMST-1:0] mst_ready = '0;
    logic sr_req, sr_ack, pad_hold, clk_req, clk_ack, cfg_alt_mode, cfg_bypass;
    logic [15:0] ref_interval, ref_cycles;

    int n_chk = 0, n_fail = 0;
    logic sr_en = 1'b1, ck_en = 1'b1;
    logic [2:0] sr_sh = '0, ck_sh = '0;
    int cyc = 0;
    int t_sr_rise, t_pad_rise, t_ck_rise, t_ck_fall, t_sr_fall;
    int viol = 0;
    logic exp_pad = 1'b0;
    logic p_sr = 1'b0, p_ck = 1'b0, p_pad = 1'b0;

    always #10 clk = ~clk;

    dfs_seq_top #(.NUM_MST(NMST), .ADDR_W(3), .TMO_W(16),
                  .TIMING_RST(TRST), .TMO_RST(16'd1000)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mst_ready(mst_ready),
        .sr_req(sr_req), .sr_ack(sr_ack), .pad_hold(pad_hold), .clk_req(clk_req),
        .clk_ack(clk_ack), .cfg_alt_mode(cfg_alt_mode), .cfg_bypass(cfg_bypass),
        .ref_interval(ref_interval), .ref_cycles(ref_cycles)
    );

    // handshake partner models: acknowledge follows request after 3 cycles
    always @(posedge clk) begin
        sr_sh <= {sr_sh[1:0], sr_req & sr_en};
        ck_sh <= {ck_sh[1:0], clk_req & ck_en};
    end
    assign sr_ack  = sr_sh[2];
    assign clk_ack = ck_sh[2];

    // event monitor, sampled away from the active edge
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (sr_req && !p_sr) t_sr_rise <= cyc;
        if (!sr_req && p_sr) t_sr_fall <= cyc;
        if (clk_req && !p_ck) t_ck_rise <= cyc;
        if (!clk_req && p_ck) t_ck_fall <= cyc;
        if (pad_hold && !p_pad) t_pad_rise <= cyc;
        if (clk_req && !(sr_req && sr_ack && pad_hold == exp_pad)) viol <= viol + 1;
        if (!sr_req && p_sr && clk_ack) viol <= viol + 1;
        p_sr <= sr_req; p_ck <= clk_req; p_pad <= pad_hold;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // wait until the start bit clears; returns cycles waited
    task automatic wait_done(output int n);
        logic [31:0] v;
        n = 0;
        forever begin
            @(negedge clk);
            rd(3'd0, v);
            if (!v[0] || n > 500) break;
            n++;
        end
    endtask

    // vectors: {buf_en, pad_en, timing value}
    localparam logic [33:0] VEC [4] = '{
        {1'b1, 1'b1, 32'h0123_0045},
        {1'b0, 1'b0, 32'h0456_0078},
        {1'b1, 1'b0, 32'h0089_00AB},
        {1'b0, 1'b1, 32'h00CD_0011}
    };

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] v, prev;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'd0, v); chk("R1 ctrl", v, 32'h0);
        rd(3'd1, v); chk("R1 mask", v, 32'h0);
        rd(3'd2, v); chk("R1 timing", v, TRST);
        rd(3'd3, v); chk("R1 shadow", v, TRST);
        chk("R1 outputs", {29'b0, sr_req, pad_hold, clk_req}, 32'h0);

        wr(3'd1, 32'hF);
        prev = TRST;
        for (int i = 0; i < 4; i++) begin
            logic bufe, pade;
            logic [31:0] tv;
            bufe = VEC[i][33]; pade = VEC[i][32]; tv = VEC[i][31:0];
            exp_pad = pade;
            wr(3'd0, {16'b0, bufe, 1'b0, pade, 13'b0});
            wr(3'd2, tv);
            rd(3'd3, v); chk("R5 shadow staged", v, tv);
            rd(3'd2, v);
            if (bufe) chk("R5 active held", v, prev);
            else      chk("R6 active direct", v, tv);
            viol = 0;
            wr(3'd0, {16'b0, bufe, 1'b0, pade, 12'b0, 1'b1});
            rd(3'd0, v); chk("R2 start reads 1", {31'b0, v[0]}, 32'h1);
            wait_done(n);
            rd(3'd0, v); chk("R2 start clears", {31'b0, v[0]}, 32'h0);
            rd(3'd2, v); chk("R5 committed", v, tv);
            chk("R8 fields", {ref_interval, ref_cycles}, tv);
            chk("R4 order", {29'b0, t_sr_rise < t_ck_rise, t_ck_fall < t_sr_fall, viol == 0}, 32'h7);
            if (pade) chk("R4 pad before clk", {31'b0, t_pad_rise < t_ck_rise}, 32'h1);
            prev = tv;
        end
        exp_pad = 1'b0;

        // R9 mode and bypass
        wr(3'd0, 32'h0000_0012);
        chk("R9 mode/bypass", {30'b0, cfg_alt_mode, cfg_bypass}, 32'h3);
        wr(3'd0, 32'h0000_0000);
        chk("R9 cleared", {30'b0, cfg_alt_mode, cfg_bypass}, 32'h0);

        // R3 stall on masters, partial mask
        wr(3'd1, 32'h1);
        mst_ready = 4'b0100;
        wr(3'd0, 32'h1);
        repeat (30) @(negedge clk);
        chk("R3 stalled", {31'b0, sr_req}, 32'h0);
        // R2 writes ignored while running
        wr(3'd0, 32'h0000_A013);
        rd(3'd0, v); chk("R2 ctrl frozen", v, 32'h1);
        mst_ready = 4'b1110;
        wait_done(n);
        rd(3'd0, v); chk("R3 completes when clear", v, 32'h0);
        mst_ready = '0;
        // R3 all ones mask, no master ready
        wr(3'd1, 32'hFFFF_FFFF);
        rd(3'd1, v); chk("R3 mask width", v, 32'hF);
        wr(3'd0, 32'h1);
        wait_done(n);
        chk("R3 all-ones mask proceeds", {31'b0, n < 100}, 32'h1);

        // R7 timeout on clock change with staged timing
        wr(3'd4, 32'd20);
        wr(3'd0, 32'h0000_8000);
        wr(3'd2, 32'h0777_0099);
        ck_en = 1'b0;
        wr(3'd0, 32'h0000_8001);
        wait_done(n);
        rd(3'd0, v); chk("R7 abort err", v, 32'h0000_8100);
        chk("R7 outputs dropped", {29'b0, sr_req, pad_hold, clk_req}, 32'h0);
        rd(3'd2, v); chk("R7 no commit", v, prev);
        ck_en = 1'b1;
        repeat (10) @(negedge clk);
        rd(3'd0, v); chk("R7 err sticky", {31'b0, v[8]}, 32'h1);
        wr(3'd0, 32'h0000_8001);
        rd(3'd0, v); chk("R7 err cleared on start", {31'b0, v[8]}, 32'h0);
        wait_done(n);
        rd(3'd2, v); chk("R5 commit after retry", v, 32'h0777_0099);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule